// File: doc/BRIEF.md
# Truncating binary32 multiplier

This block multiplies two single-precision floating-point words and returns the product two clock cycles later. It uses a short datapath: the sign is the exclusive-or of the operand signs, the biased exponents are added and re-biased, and the two 24-bit significands (hidden one restored) form a 48-bit product. One test of the product's top bit picks which 23-bit window becomes the result fraction. The bits below that window are simply dropped, so the result is never rounded.

The block is meant for a feed-forward arithmetic pipeline where operands are already normal numbers. An operand whose exponent field is zero is treated as zero. A result exponent below one is flushed to a signed zero. A result exponent above the largest field value raises an overflow flag and saturates the magnitude to all ones. There is no back-pressure: one operand pair may enter per cycle, and each produces exactly one result.

Top module: `fp32_trunc_mul`

## Requirements
- R1: The result sign (bit 31) equals the exclusive-or of the sign bits (bit 31) of the two operands, in every case including zero, flush and overflow results.
- R2: When bit 47 of the significand product is 0, the result fraction (bits 22:0) is product bits 45:23 and the result exponent field (bits 30:23) is ea + eb - 127, where ea and eb are the operand exponent fields.
- R3: When bit 47 of the significand product is 1, the result fraction is product bits 46:24 and the result exponent field is ea + eb - 127 + 1.
- R4: When the result exponent (after the adjustment of R3) is greater than 255, the overflow flag is 1 and bits 30:0 of the result are all ones. A result exponent of exactly 255 is packed normally with the flag at 0.
- R5: When either operand has an exponent field of 0, the result is a signed zero (bits 30:0 zero) and the overflow flag is 0, whatever the other operand holds.
- R6: When the result exponent is less than 1, the result is a signed zero and the overflow flag is 0.
- R7: The output valid is high exactly two cycles after the input valid, once per accepted pair. Pairs may enter on consecutive cycles and leave in the same order, one per cycle.
- R8: While reset is held and after its release, before any input is accepted, the output valid, result and overflow flag are all 0.
- R9: Product bits below the selected window are discarded with no rounding. For example, 0x3FC00000 times 0x3F800001 gives 0x3FC00001, even though the dropped bits are exactly one half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair present this cycle |
| op_a | input | 32 | First operand, binary32 encoding |
| op_b | input | 32 | Second operand, binary32 encoding |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | 32 | Product, binary32 encoding |
| out_ovf | output | 1 | Exponent overflow flag for the present result |

## Verification
The bench builds the block with its default widths: an 8-bit exponent and a 23-bit fraction. This lets every directed vector be written as a binary32 hex word whose decimal meaning can be checked by hand. It also puts the exact exponent boundaries within reach: a result exponent of 255, overflow that only appears after the bit-47 increment, and an exponent of 0 versus 1. A pseudo-random stream, sent on consecutive cycles, compares each result against an integer model of the requirements and checks the ordering of back-to-back results.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  // default binary32 field widths
  localparam int FPM_EXP_W  = 8;
  localparam int FPM_FRAC_W = 23;

  // outcome of the pack stage
  typedef enum logic [1:0] {
    KIND_NORMAL = 2'd0,
    KIND_ZERO   = 2'd1,
    KIND_FLUSH  = 2'd2,
    KIND_OVF    = 2'd3
  } fpm_kind_e;
endpackage

// File: rtl/fpm_sig_stage.sv
module fpm_sig_stage
  import fpm_pkg::*;
#(
  parameter int EXP_W  = FPM_EXP_W,
  parameter int FRAC_W = FPM_FRAC_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [EXP_W+FRAC_W:0]   op_a,
  input  logic [EXP_W+FRAC_W:0]   op_b,
  output logic                    s1_valid,
  output logic                    s1_sign,
  output logic                    s1_zero,
  output logic signed [EXP_W+1:0] s1_exp,
  output logic [FRAC_W+1:0]       s1_keep
);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int KEEP_W = SIG_W + 1;
  localparam int XE_W   = EXP_W + 2;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;

  // operand fields, unpacked the same way for both operands
  logic [WORD_W-1:0] opw   [2];
  logic [EXP_W-1:0]  op_e  [2];
  logic [SIG_W-1:0]  op_m  [2];
  logic              op_s  [2];
  logic              op_z  [2];

  assign opw[0] = op_a;
  assign opw[1] = op_b;

  for (genvar gi = 0; gi < 2; gi++) begin : g_unpack
    assign op_s[gi] = opw[gi][WORD_W-1];
    assign op_e[gi] = opw[gi][WORD_W-2 -: EXP_W];
    assign op_m[gi] = {1'b1, opw[gi][FRAC_W-1:0]};
    assign op_z[gi] = (op_e[gi] == '0);
  end

  // biased exponent sum with one bias removed, wide enough to hold the sign
  function automatic logic signed [XE_W-1:0] f_exp_sum(
    input logic [EXP_W-1:0] ea,
    input logic [EXP_W-1:0] eb
  );
    logic signed [XE_W-1:0] t;
    t = $signed({2'b00, ea}) + $signed({2'b00, eb}) - $signed(XE_W'(BIAS));
    return t;
  endfunction

  // significand product; only the bits either output window can use are kept
  function automatic logic [KEEP_W-1:0] f_sig_keep(
    input logic [SIG_W-1:0] ma,
    input logic [SIG_W-1:0] mb
  );
    logic [PROD_W-1:0] p;
    p = PROD_W'(ma) * PROD_W'(mb);
    return p[PROD_W-1 -: KEEP_W];
  endfunction

  wire                    ev_zero_in = op_z[0] | op_z[1];
  wire                    sign_nx    = op_s[0] ^ op_s[1];
  wire signed [XE_W-1:0]  exp_nx     = f_exp_sum(op_e[0], op_e[1]);
  wire [KEEP_W-1:0]       keep_nx    = f_sig_keep(op_m[0], op_m[1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_sign  <= 1'b0;
      s1_zero  <= 1'b0;
      s1_exp   <= '0;
      s1_keep  <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_sign <= sign_nx;
        s1_zero <= ev_zero_in;
        s1_exp  <= exp_nx;
        s1_keep <= keep_nx;
      end
    end
  end

  // R5: an operand with a zero exponent field marks the staged pair as zero
  a_r5_zero_mark: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ev_zero_in) |=> s1_zero);

  // R3: with both hidden ones set the kept product always has a one in its top two bits
  a_r3_lead_one: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (s1_keep[KEEP_W-1] | s1_keep[KEEP_W-2]));
endmodule

// File: rtl/fpm_pack_stage.sv
module fpm_pack_stage
  import fpm_pkg::*;
#(
  parameter int EXP_W  = FPM_EXP_W,
  parameter int FRAC_W = FPM_FRAC_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    s1_valid,
  input  logic                    s1_sign,
  input  logic                    s1_zero,
  input  logic signed [EXP_W+1:0] s1_exp,
  input  logic [FRAC_W+1:0]       s1_keep,
  output logic                    out_valid,
  output logic [EXP_W+FRAC_W:0]   out_result,
  output logic                    out_ovf
);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int KEEP_W = FRAC_W + 2;
  localparam int XE_W   = EXP_W + 2;
  localparam int EMAX   = (1 << EXP_W) - 1;

  // exponent after the normalisation step
  function automatic logic signed [XE_W-1:0] f_adj_exp(
    input logic signed [XE_W-1:0] e,
    input logic                   top
  );
    return e + $signed(XE_W'(top));
  endfunction

  // fraction window chosen by the top product bit, low bits dropped
  function automatic logic [FRAC_W-1:0] f_frac(
    input logic [KEEP_W-1:0] k,
    input logic              top
  );
    return top ? k[KEEP_W-2 -: FRAC_W] : k[KEEP_W-3 -: FRAC_W];
  endfunction

  // priority: zero operand, then overflow, then flush
  function automatic fpm_kind_e f_kind(
    input logic                   zero,
    input logic signed [XE_W-1:0] e
  );
    if (zero)                            return KIND_ZERO;
    if (e > $signed(XE_W'(EMAX)))        return KIND_OVF;
    if (e < $signed(XE_W'(1)))           return KIND_FLUSH;
    return KIND_NORMAL;
  endfunction

  wire                   ev_top   = s1_keep[KEEP_W-1];
  wire signed [XE_W-1:0] adj_exp  = f_adj_exp(s1_exp, ev_top);
  wire [FRAC_W-1:0]      frac_sel = f_frac(s1_keep, ev_top);
  fpm_kind_e             kind;
  assign kind = f_kind(s1_zero, adj_exp);
  wire                   ev_ovf   = (kind == KIND_OVF);
  wire                   ev_flush = (kind == KIND_FLUSH) | (kind == KIND_ZERO);

  logic [WORD_W-1:0] word_nx;
  always_comb begin
    unique case (kind)
      KIND_NORMAL: word_nx = {s1_sign, adj_exp[EXP_W-1:0], frac_sel};
      KIND_OVF:    word_nx = {s1_sign, {(WORD_W-1){1'b1}}};
      default:     word_nx = {s1_sign, {(WORD_W-1){1'b0}}};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_ovf    <= 1'b0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_result <= word_nx;
        out_ovf    <= ev_ovf;
      end
    end
  end

  // R1: staged sign reaches the result bit unchanged
  a_r1_sign: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> (out_result[WORD_W-1] == $past(s1_sign)));

  // R3: top bit set on a normal result selects the upper window
  a_r3_window: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && ev_top && kind == KIND_NORMAL)
      |=> (out_result[FRAC_W-1:0] == $past(s1_keep[KEEP_W-2:1])));

  // R4: the overflow flag comes only with a saturated magnitude
  a_r4_saturate: assert property (@(posedge clk) disable iff (rst)
    out_ovf |-> (out_result[WORD_W-2:0] == {(WORD_W-1){1'b1}}));

  // R5: a zero operand never raises overflow
  a_r5_no_ovf: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_zero) |=> (!out_ovf && out_result[WORD_W-2:0] == '0));

  // R6: an exponent below one flushes to a signed zero
  a_r6_flush: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && ev_flush) |=> (!out_ovf && out_result[WORD_W-2:0] == '0));
endmodule

// File: rtl/fp32_trunc_mul.sv
module fp32_trunc_mul
  import fpm_pkg::*;
#(
  parameter int EXP_W  = FPM_EXP_W,
  parameter int FRAC_W = FPM_FRAC_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [EXP_W+FRAC_W:0] op_a,
  input  logic [EXP_W+FRAC_W:0] op_b,
  output logic                  out_valid,
  output logic [EXP_W+FRAC_W:0] out_result,
  output logic                  out_ovf
);
  localparam int XE_W   = EXP_W + 2;
  localparam int KEEP_W = FRAC_W + 2;

  logic                   s1_valid;
  logic                   s1_sign;
  logic                   s1_zero;
  logic signed [XE_W-1:0] s1_exp;
  logic [KEEP_W-1:0]      s1_keep;

  fpm_sig_stage #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_sig (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .op_a     (op_a),
    .op_b     (op_b),
    .s1_valid (s1_valid),
    .s1_sign  (s1_sign),
    .s1_zero  (s1_zero),
    .s1_exp   (s1_exp),
    .s1_keep  (s1_keep)
  );

  fpm_pack_stage #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_pack (
    .clk        (clk),
    .rst        (rst),
    .s1_valid   (s1_valid),
    .s1_sign    (s1_sign),
    .s1_zero    (s1_zero),
    .s1_exp     (s1_exp),
    .s1_keep    (s1_keep),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_ovf    (out_ovf)
  );

  // set after the first clock out of reset, so $past never reaches into reset
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R7: each stage passes valid on after exactly one clock
  a_r7_stage1: assert property (@(posedge clk) disable iff (rst || !past_ok)
    s1_valid == $past(in_valid));
  a_r7_stage2: assert property (@(posedge clk) disable iff (rst || !past_ok)
    out_valid == $past(s1_valid));

  // R8: outputs stay quiet while reset is held
  a_r8_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !out_ovf && out_result == '0));
endmodule

// File: tb/fp32_trunc_mul_tb_top.sv
module fp32_trunc_mul_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_ovf;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  fp32_trunc_mul dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .out_result(out_result), .out_ovf(out_ovf)
  );

  // reference built from the requirement text with integer arithmetic
  function automatic logic [32:0] model(input logic [31:0] a, input logic [31:0] b);
    longint ma, mb, p, fr;
    int     e;
    logic   s;
    s = a[31] ^ b[31];
    if (a[30:23] == 0 || b[30:23] == 0) return {1'b0, s, 31'd0};
    ma = longint'({1'b1, a[22:0]});
    mb = longint'({1'b1, b[22:0]});
    p  = ma * mb;
    e  = int'(a[30:23]) + int'(b[30:23]) - 127;
    if (p >= (64'd1 << 47)) begin
      fr = (p / (64'd1 << 24)) % (64'd1 << 23);
      e  = e + 1;
    end else begin
      fr = (p / (64'd1 << 23)) % (64'd1 << 23);
    end
    if (e > 255) return {1'b1, s, 31'h7FFF_FFFF};
    if (e < 1)   return {1'b0, s, 31'd0};
    return {1'b0, s, 8'(e), 23'(fr)};
  endfunction

  task automatic check(input string tag, input logic [31:0] got_r, input logic got_o,
                       input logic [31:0] exp_r, input logic exp_o);
    n_checks++;
    if (got_r !== exp_r || got_o !== exp_o) begin
      n_fail++;
      $display("FAIL %s: result=%h ovf=%b expected result=%h ovf=%b",
               tag, got_r, got_o, exp_r, exp_o);
    end
  endtask

  // one pair, checks the exact cycle the result appears
  task automatic run_vec(input string tag, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] exp_r, input logic exp_o);
    @(negedge clk);
    op_a = a; op_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    n_checks++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R7 %s: out_valid=%b after one cycle expected 0", tag, out_valid);
    end
    @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b1) begin
      n_fail++;
      $display("FAIL R7 %s: out_valid=%b after two cycles expected 1", tag, out_valid);
    end
    check(tag, out_result, out_ovf, exp_r, exp_o);
    if (model(a, b) !== {exp_o, exp_r})
      check({tag, " model"}, model(a, b)[31:0], model(a, b)[32], exp_r, exp_o);
  endtask

  task automatic t_reset;
    n_checks++;
    if (out_valid !== 1'b0 || out_result !== 32'd0 || out_ovf !== 1'b0) begin
      n_fail++;
      $display("FAIL R8: valid=%b result=%h ovf=%b expected 0 00000000 0",
               out_valid, out_result, out_ovf);
    end
  endtask

  task automatic t_basic;
    run_vec("R2 2*3",        32'h4000_0000, 32'h4040_0000, 32'h40C0_0000, 1'b0);
    run_vec("R1 -2*3",       32'hC000_0000, 32'h4040_0000, 32'hC0C0_0000, 1'b0);
    run_vec("R1 -2*-3",      32'hC000_0000, 32'hC040_0000, 32'h40C0_0000, 1'b0);
    run_vec("R3 1.5*1.5",    32'h3FC0_0000, 32'h3FC0_0000, 32'h4010_0000, 1'b0);
    run_vec("R3 max frac",   32'h3FFF_FFFF, 32'h3FFF_FFFF, 32'h407F_FFFE, 1'b0);
  endtask

  task automatic t_trunc;
    run_vec("R9 half dropped", 32'h3FC0_0000, 32'h3F80_0001, 32'h3FC0_0001, 1'b0);
  endtask

  task automatic t_overflow;
    run_vec("R4 exp 255 no ovf", 32'h7F00_0000, 32'h4000_0000, 32'h7F80_0000, 1'b0);
    run_vec("R4 big*big",        32'h7F00_0000, 32'h7F00_0000, 32'h7FFF_FFFF, 1'b1);
    run_vec("R4 neg ovf",        32'hFF00_0000, 32'h7F00_0000, 32'hFFFF_FFFF, 1'b1);
    run_vec("R4 ovf by R3 step", 32'h7F40_0000, 32'h4040_0000, 32'h7FFF_FFFF, 1'b1);
  endtask

  task automatic t_zero;
    run_vec("R5 +0*3",        32'h0000_0000, 32'h4040_0000, 32'h0000_0000, 1'b0);
    run_vec("R5 -0*3",        32'h8000_0000, 32'h4040_0000, 32'h8000_0000, 1'b0);
    run_vec("R5 subnormal",   32'h4040_0000, 32'h0000_0001, 32'h0000_0000, 1'b0);
    run_vec("R5 0*big no ovf", 32'h7F00_0000, 32'h8000_0000, 32'h8000_0000, 1'b0);
  endtask

  task automatic t_flush;
    run_vec("R6 exp 0",     32'h0080_0000, 32'h3F00_0000, 32'h0000_0000, 1'b0);
    run_vec("R6 neg exp 0", 32'h8080_0000, 32'h3F00_0000, 32'h8000_0000, 1'b0);
    run_vec("R6 exp 1",     32'h0080_0000, 32'h3F80_0000, 32'h0080_0000, 1'b0);
  endtask

  // consecutive pairs compared against the model in arrival order
  task automatic t_stream;
    logic [31:0] va [64];
    logic [31:0] vb [64];
    logic [31:0] lf;
    int          rx;
    lf = 32'hACE1_1234;
    for (int i = 0; i < 64; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      va[i] = lf;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      vb[i] = {lf[31], 2'b01 ^ {1'b0, lf[5]}, lf[28:0]};
      if (i % 7 == 3) va[i][30:23] = 8'd0;
      if (i % 11 == 5) va[i][30:23] = 8'hF0;
    end
    rx = 0;
    @(negedge clk);
    for (int i = 0; i < 66; i++) begin
      if (out_valid) begin
        check("R7 stream", out_result, out_ovf, model(va[rx], vb[rx])[31:0],
              model(va[rx], vb[rx])[32]);
        rx++;
      end
      if (i < 64) begin
        op_a = va[i]; op_b = vb[i]; in_valid = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
      @(negedge clk);
    end
    if (out_valid) begin
      check("R7 stream", out_result, out_ovf, model(va[rx], vb[rx])[31:0],
            model(va[rx], vb[rx])[32]);
      rx++;
    end
    n_checks++;
    if (rx != 64) begin
      n_fail++;
      $display("FAIL R7 stream count: got %0d results expected 64", rx);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_trunc();
    t_overflow();
    t_zero();
    t_flush();
    t_stream();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule